// File: doc/BRIEF.md
# Byte-Laned Static RAM Model

This block models a 16-bit asynchronous static RAM inside a clocked design. The control pins are all active low: chip select, output enable, write enable, lower-lane enable and upper-lane enable. A 16-bit word address accompanies them. The block samples these inputs on every rising clock edge. The bidirectional data bus is split into three parts: a data input, a data output, and a per-lane drive-enable pair. A surrounding pad ring or bus model can join them into a tristate bus.

A write is open while chip select and write enable are both low. During that time the block keeps the latest sampled address, data and lane enables. The write closes at the first sample where either control is high, and the held value is then committed to the enabled lanes only. Reads are registered and drive only the lanes whose enables are low. A 3-bit mode output reports how the block decoded the sampled controls. The storage depth is a parameter, so a simulation can use a small array in place of the full 64K words.

The controller has three named states:
- `ST_STANDBY`: chip deselected.
- `ST_SELECT`: selected, no write open.
- `ST_WRITE`: write open.

Its transitions are:
- **open**: any state goes to `ST_WRITE` when chip select and write enable are both low.
- **hold**: `ST_WRITE` stays in `ST_WRITE` while the write stays open.
- **close**: `ST_WRITE` goes to `ST_SELECT` or `ST_STANDBY` when the write ends, and the commit happens on this transition.
- **select / deselect**: `ST_STANDBY` and `ST_SELECT` move between each other as chip select changes.

Top module: `lanesram_top`

## Requirements
- R1: While reset is low and after it is released, with no access made, dq_oe is 00, dq_out is 0000 and mode is 0 (standby).
- R2: Chip select high gives mode 0 and dq_oe 00 whatever the other controls are, and it writes nothing.
- R3: A read is chip select low, output enable low and write enable high. In a read, lane 0 (dq_oe[0], dq_out[7:0]) drives when the lower enable is low, and lane 1 (dq_oe[1], dq_out[15:8]) drives when the upper enable is low. Mode is 2 for a lower-only read, 3 for an upper-only read and 4 for a word read. The bits of a lane that is not driving read 0.
- R4: With chip select low and both lane enables high, mode is 1 (output disabled) and no lane drives, even with output enable low. A write attempted this way changes nothing. Chip select low with both output enable and write enable high also gives mode 1.
- R5: With chip select low and write enable low, output enable is ignored and no lane drives. Mode is 5 for a lower-only write, 6 for an upper-only write and 7 for a word write.
- R6: A write closes at the first sample where chip select or write enable is high. At that sample the block commits the address, data and lane enables from the last sample at which both were low. Lanes that were not enabled keep their contents, and the rising of either control ends the write in the same way.
- R7: Outputs are registered. dq_out, dq_oe and mode change only at a rising edge, and they reflect the inputs sampled at that edge.
- R8: A read sampled at the same edge that closes a write to the same address returns the newly committed lanes merged with the old contents of the other lanes.
- R9: Only the low log2(DEPTH) address bits select a word, so addresses that differ by a multiple of DEPTH (a power of two) reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower lane (bits 7:0) enable, active low |
| ub_n | input | 1 | Upper lane (bits 15:8) enable, active low |
| addr | input | 16 | Word address |
| dq_in | input | 16 | Data from the bus side |
| dq_out | output | 16 | Data driven toward the bus |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 lower, bit 1 upper |
| mode | output | 3 | Decoded access mode, 0 to 7 |

## Verification
The bench covers these corner cases:
- **Write closing.** Writes are closed once by chip select rising and once by write enable rising. A model that commits only on write enable would lose the first of these.
- **Held value.** Data and address change while a write stays open. A design that latches on the first sample stores the wrong word.
- **Lane masking.** Single-lane writes are read back as whole words. Masking that is missing or inverted corrupts the neighbouring byte.
- **Forwarding.** A read of the same address lands on the closing sample. Without the forward path the old data comes back.
- **Priority.** Output enable is held low during a write, and a write is attempted with no lane enabled. A decoder that gets these wrong drives the bus during a write or commits a word.

// File: rtl/lanesram_pkg.sv
package lanesram_pkg;

    localparam int ADDR_W = 16;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        MD_STANDBY  = 3'd0,
        MD_DISABLED = 3'd1,
        MD_RD_LO    = 3'd2,
        MD_RD_HI    = 3'd3,
        MD_RD_WORD  = 3'd4,
        MD_WR_LO    = 3'd5,
        MD_WR_HI    = 3'd6,
        MD_WR_WORD  = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_SELECT  = 2'd1,
        ST_WRITE   = 2'd2
    } state_e;

endpackage

// File: rtl/lanesram_decode.sv
module lanesram_decode
    import lanesram_pkg::*;
(
    input  logic             cs_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             lb_n,
    input  logic             ub_n,
    output mode_e            mode,
    output logic [LANES-1:0] rd_lanes,
    output logic [LANES-1:0] wr_lanes,
    output logic             write_now
);

    logic [LANES-1:0] lane_on;

    assign lane_on   = ~{ub_n, lb_n};
    assign write_now = !cs_n && !we_n;
    assign wr_lanes  = lane_on;
    assign rd_lanes  = (!cs_n && we_n && !oe_n) ? lane_on : '0;

    always_comb begin
        mode = MD_STANDBY;
        if (cs_n) begin
            mode = MD_STANDBY;
        end else if (lane_on == '0) begin
            mode = MD_DISABLED;
        end else if (!we_n) begin
            unique case (lane_on)
                2'b01:   mode = MD_WR_LO;
                2'b10:   mode = MD_WR_HI;
                default: mode = MD_WR_WORD;
            endcase
        end else if (oe_n) begin
            mode = MD_DISABLED;
        end else begin
            unique case (lane_on)
                2'b01:   mode = MD_RD_LO;
                2'b10:   mode = MD_RD_HI;
                default: mode = MD_RD_WORD;
            endcase
        end
    end

endmodule

// File: rtl/lanesram_ctrl.sv
module lanesram_ctrl
    import lanesram_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              write_now,
    input  logic [LANES-1:0]  lanes_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [IDX_W-1:0]  cm_idx,
    output logic [DATA_W-1:0] cm_data,
    output logic [LANES-1:0]  cm_lanes
);

    state_e state_q, state_d;
    logic [IDX_W-1:0]  hold_idx_q;
    logic [DATA_W-1:0] hold_data_q;
    logic [LANES-1:0]  hold_lanes_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: state_d = write_now ? ST_WRITE : (cs_n ? ST_STANDBY : ST_SELECT);
            ST_SELECT:  state_d = write_now ? ST_WRITE : (cs_n ? ST_STANDBY : ST_SELECT);
            ST_WRITE:   state_d = write_now ? ST_WRITE : (cs_n ? ST_STANDBY : ST_SELECT);
            default:    state_d = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_idx_q   <= '0;
            hold_data_q  <= '0;
            hold_lanes_q <= '0;
        end else if (write_now) begin
            hold_idx_q   <= idx_in;
            hold_data_q  <= din;
            hold_lanes_q <= lanes_in;
        end
    end

    always_comb begin
        commit   = (state_q == ST_WRITE) && !write_now;
        cm_idx   = hold_idx_q;
        cm_data  = hold_data_q;
        cm_lanes = hold_lanes_q;
    end

    p_commit_after_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(write_now));

    p_write_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        write_now |=> state_q == ST_WRITE);

endmodule

// File: rtl/lanesram_array.sv
module lanesram_array
    import lanesram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                mem[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_idx];
    end

endmodule

// File: rtl/lanesram_top.sv
module lanesram_top
    import lanesram_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        lb_n,
    input  logic        ub_n,
    input  logic [15:0] addr,
    input  logic [15:0] dq_in,
    output logic [15:0] dq_out,
    output logic [1:0]  dq_oe,
    output logic [2:0]  mode
);

    localparam int IDX_W = $clog2(DEPTH);

    mode_e             dec_mode;
    logic [LANES-1:0]  rd_lanes;
    logic [LANES-1:0]  wr_lanes;
    logic              write_now;
    logic [IDX_W-1:0]  idx;
    logic              commit;
    logic [IDX_W-1:0]  cm_idx;
    logic [DATA_W-1:0] cm_data;
    logic [LANES-1:0]  cm_lanes;
    logic [DATA_W-1:0] rd_raw;
    logic [DATA_W-1:0] rd_fwd;
    logic [DATA_W-1:0] dout_q;
    logic [LANES-1:0]  oe_q;
    mode_e             mode_q;

    assign idx = addr[IDX_W-1:0];

    if (IDX_W < ADDR_W) begin : g_alias
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:IDX_W];
    end

    lanesram_decode u_dec (
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .lb_n      (lb_n),
        .ub_n      (ub_n),
        .mode      (dec_mode),
        .rd_lanes  (rd_lanes),
        .wr_lanes  (wr_lanes),
        .write_now (write_now)
    );

    lanesram_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .write_now (write_now),
        .lanes_in  (wr_lanes),
        .idx_in    (idx),
        .din       (dq_in),
        .commit    (commit),
        .cm_idx    (cm_idx),
        .cm_data   (cm_data),
        .cm_lanes  (cm_lanes)
    );

    lanesram_array #(.DEPTH(DEPTH)) u_arr (
        .clk      (clk),
        .wr_en    (commit),
        .wr_idx   (cm_idx),
        .wr_data  (cm_data),
        .wr_lanes (cm_lanes),
        .rd_idx   (idx),
        .rd_data  (rd_raw)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign rd_fwd[g*LANE_W +: LANE_W] =
            (commit && cm_lanes[g] && cm_idx == idx) ? cm_data[g*LANE_W +: LANE_W]
                                                     : rd_raw[g*LANE_W +: LANE_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           dout_q[g*LANE_W +: LANE_W] <= '0;
            else if (rd_lanes[g]) dout_q[g*LANE_W +: LANE_W] <= rd_fwd[g*LANE_W +: LANE_W];
            else                  dout_q[g*LANE_W +: LANE_W] <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q   <= '0;
            mode_q <= MD_STANDBY;
        end else begin
            oe_q   <= rd_lanes;
            mode_q <= dec_mode;
        end
    end

    assign dq_out = dout_q;
    assign dq_oe  = oe_q;
    assign mode   = mode_q;

    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (dq_oe == 2'b00 && mode == 3'd0));

    p_read_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_n && !oe_n && we_n) |-> dq_oe == ~$past({ub_n, lb_n}));

    p_idle_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe[0] |-> dq_out[7:0] == 8'h00);

    p_no_lane_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_n && lb_n && ub_n) |-> (dq_oe == 2'b00 && mode == 3'd1));

    p_write_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_n && !we_n) |-> dq_oe == 2'b00);

    p_commit_on_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cs_n || we_n));

endmodule

// File: tb/sim_lanesram_top.sv
module sim_lanesram_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [2:0]  mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lanesram_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic c, input logic o, input logic w,
                         input logic l, input logic u,
                         input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cs_n = c; oe_n = o; we_n = w; lb_n = l; ub_n = u; addr = a; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d,
                      input logic l, input logic u);
        apply(1'b0, 1'b1, 1'b0, l, u, a, d);
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, a, 16'h0);
    endtask

    task automatic rd(input logic [15:0] a);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0);
    endtask

    task automatic t_reset;
        #1;
        check("R1", "oe in reset", {14'b0, dq_oe}, 16'h0);
        check("R1", "mode in reset", {13'b0, mode}, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "data after reset", dq_out, 16'h0);
        check("R1", "oe after reset", {14'b0, dq_oe}, 16'h0);
    endtask

    task automatic t_word_and_lanes;
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd5, 16'hA55A);
        check("R5", "word write mode", {13'b0, mode}, 16'd7);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd5, 16'h0);
        check("R4", "oe high mode", {13'b0, mode}, 16'd1);
        rd(16'd5);
        check("R3", "word read data", dq_out, 16'hA55A);
        check("R3", "word read oe", {14'b0, dq_oe}, 16'h3);
        check("R3", "word read mode", {13'b0, mode}, 16'd4);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'd5, 16'h0);
        check("R3", "lower read data", dq_out, 16'h005A);
        check("R3", "lower read oe", {14'b0, dq_oe}, 16'h1);
        check("R3", "lower read mode", {13'b0, mode}, 16'd2);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd5, 16'h0);
        check("R3", "upper read data", dq_out, 16'hA500);
        check("R3", "upper read oe", {14'b0, dq_oe}, 16'h2);
        check("R3", "upper read mode", {13'b0, mode}, 16'd3);
    endtask

    task automatic t_lane_masks;
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd5, 16'h1234);
        check("R5", "lower write mode", {13'b0, mode}, 16'd5);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'd5, 16'h0);
        check("R2", "close by deselect mode", {13'b0, mode}, 16'd0);
        rd(16'd5);
        check("R6", "lower write masked", dq_out, 16'hA534);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd5, 16'hBEEF);
        check("R5", "upper write mode", {13'b0, mode}, 16'd6);
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd5, 16'h0);
        rd(16'd5);
        check("R6", "upper write masked", dq_out, 16'hBE34);
    endtask

    task automatic t_ignored;
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd5, 16'h0);
        check("R4", "no lane read oe", {14'b0, dq_oe}, 16'h0);
        check("R4", "no lane read mode", {13'b0, mode}, 16'd1);
        wr(16'd5, 16'hFFFF, 1'b1, 1'b1);
        rd(16'd5);
        check("R4", "no lane write kept", dq_out, 16'hBE34);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5, 16'h7E7E);
        check("R5", "oe ignored in write", {14'b0, dq_oe}, 16'h0);
        check("R5", "oe ignored mode", {13'b0, mode}, 16'd7);
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'd5, 16'h0);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5, 16'h0000);
        check("R2", "deselected oe", {14'b0, dq_oe}, 16'h0);
        check("R2", "deselected mode", {13'b0, mode}, 16'd0);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'd5, 16'h0);
        rd(16'd5);
        check("R2", "deselected write ignored", dq_out, 16'h7E7E);
    endtask

    task automatic t_last_sample;
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd9, 16'h1111);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd9, 16'h2222);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd9, 16'h0);
        rd(16'd9);
        check("R6", "last data wins", dq_out, 16'h2222);
        wr(16'd10, 16'h0000, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd10, 16'h3333);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd11, 16'h4444);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'd0, 16'h0);
        rd(16'd11);
        check("R6", "last address wins", dq_out, 16'h4444);
        rd(16'd10);
        check("R6", "earlier address untouched", dq_out, 16'h0000);
    endtask

    task automatic t_forward;
        wr(16'd20, 16'h0101, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd20, 16'h9999);
        rd(16'd20);
        check("R8", "forward word", dq_out, 16'h9999);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd20, 16'h00AA);
        rd(16'd20);
        check("R8", "forward lower merge", dq_out, 16'h99AA);
    endtask

    task automatic t_latency;
        rd(16'd5);
        @(negedge clk);
        addr = 16'd9;
        #1;
        check("R7", "held before edge", dq_out, 16'h7E7E);
        @(posedge clk); #1;
        check("R7", "updated after edge", dq_out, 16'h2222);
    endtask

    task automatic t_alias;
        wr(16'd3, 16'hCAFE, 1'b0, 1'b0);
        rd(16'd3 + 16'(DEPTH));
        check("R9", "alias read", dq_out, 16'hCAFE);
        wr(16'd7 + 16'(DEPTH), 16'h4242, 1'b0, 1'b0);
        rd(16'd7);
        check("R9", "alias write", dq_out, 16'h4242);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_word_and_lanes();
        t_lane_masks();
        t_ignored();
        t_last_sample();
        t_forward();
        t_latency();
        t_alias();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule